// File: doc/BRIEF.md
# Three-Source Event Interrupt Controller

This block gathers three event lines into one interrupt request. Each event line has its own trigger mode, fixed at build time. The modes are level, rising edge and falling edge. A triggered event latches a pending bit. Software reads and changes the block through a small Wishbone classic slave with an 8-bit data bus. Through that slave it can see the raw line levels, read the pending bits and acknowledge them, and choose which pending bits may raise the interrupt.

Software writes ones to the pending register to acknowledge events. Bits written as zero are left alone. A level-mode event keeps setting its pending bit for as long as its line stays high, so acknowledging it only takes effect once the line is low. The interrupt output is a registered OR of all pending bits that are also enabled.

The bus side is a two-state machine. BUS_IDLE waits for a strobe. A strobe while idle performs the access in that cycle and moves to BUS_ACK (transition "accept"). BUS_ACK drives the acknowledge for one cycle and always returns to BUS_IDLE (transition "release").

Top module: `evirq_ctrl`

## Requirements
- R1: Register address 0 (status) reads the current raw levels of the event inputs, with event i in bit i. Writes to it have no effect.
- R2: Event 0 is level-triggered. While its input is high at a clock edge, pending bit 0 is set.
- R3: Event 1 is rising-edge-triggered. A 0→1 change of its input sets pending bit 1 and no other pending bit.
- R4: Event 2 is falling-edge-triggered. A 1→0 change of its input sets pending bit 2 and no other pending bit.
- R5: Register address 1 (pending) clears each pending bit written as 1. Bits written as 0 are unchanged.
- R6: The interrupt output equals the OR of (pending AND enable) one clock later. It stays low while the enable register is zero, even with events pending.
- R7: Register address 2 (enable) is read/write in bits 2:0. Upper bits of every register read as 0, and address 3 reads 0.
- R8: A level-mode event whose input is still high stays pending after a clear, and the interrupt stays asserted.
- R9: If an edge trigger and a clear of the same bit occur in the same cycle, the bit stays pending.
- R10: A strobe seen in BUS_IDLE produces an acknowledge in the next cycle that lasts exactly one cycle. Read data is captured in the same cycle as the access.
- R11: After reset the pending and enable registers are 0, and both the interrupt and the acknowledge are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 2 | Register address |
| wb_dat_i | input | 8 | Write data |
| wb_dat_o | output | 8 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| ev_i | input | 3 | Event lines, event i on bit i |
| irq_o | output | 1 | Interrupt request |

## Verification
The two functions that can collide are an event trigger setting a pending bit and a bus write clearing that same bit at the same clock edge. To provoke the collision, the bench first makes bit 1 pending and lowers its input. It then raises input 1 on the same falling edge at which it presents a clear of bit 1. The rising edge and the clear are therefore sampled together. A following read must return 0b010, because the set wins. A separate plain clear afterwards must return 0, which confirms that the clear path works on its own.

// File: rtl/evirq_pkg.sv
package evirq_pkg;
    typedef enum logic [1:0] {
        TRIG_LEVEL = 2'd0,
        TRIG_RISE  = 2'd1,
        TRIG_FALL  = 2'd2
    } trig_e;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_ACK  = 1'b1
    } bus_state_e;

    localparam int unsigned REG_STATUS  = 0;
    localparam int unsigned REG_PENDING = 1;
    localparam int unsigned REG_ENABLE  = 2;
endpackage

// File: rtl/evirq_detect.sv
module evirq_detect #(
    parameter int unsigned          N_EV     = 3,
    parameter logic [2*N_EV-1:0]    MODE_CFG = {2'd2, 2'd1, 2'd0}
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_EV-1:0] ev_i,
    output logic [N_EV-1:0] trig_o
);
    logic [N_EV-1:0] ev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ev_q <= '0;
        else         ev_q <= ev_i;
    end

    for (genvar g = 0; g < N_EV; g++) begin : g_ev
        localparam evirq_pkg::trig_e MODE = evirq_pkg::trig_e'(MODE_CFG[2*g +: 2]);
        if (MODE == evirq_pkg::TRIG_RISE) begin : g_rise
            assign trig_o[g] = ev_i[g] & ~ev_q[g];
        end else if (MODE == evirq_pkg::TRIG_FALL) begin : g_fall
            assign trig_o[g] = ~ev_i[g] & ev_q[g];
        end else begin : g_level
            assign trig_o[g] = ev_i[g];
        end
    end
endmodule

// File: rtl/evirq_pending.sv
module evirq_pending #(
    parameter int unsigned N_EV = 3
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic [N_EV-1:0] set_i,
    input  logic [N_EV-1:0] clr_i,
    output logic [N_EV-1:0] pend_o
);
    for (genvar g = 0; g < N_EV; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)        pend_o[g] <= 1'b0;
            else if (set_i[g])  pend_o[g] <= 1'b1;
            else if (clr_i[g])  pend_o[g] <= 1'b0;
        end

        // R9
        set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (set_i[g] && clr_i[g]) |=> pend_o[g]);

        // R5
        clear_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr_i[g] && !set_i[g]) |=> !pend_o[g]);
    end
endmodule

// File: rtl/evirq_regs.sv
module evirq_regs #(
    parameter int unsigned N_EV = 3,
    parameter int unsigned DW   = 8,
    parameter int unsigned AW   = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wb_cyc_i,
    input  logic            wb_stb_i,
    input  logic            wb_we_i,
    input  logic [AW-1:0]   wb_adr_i,
    input  logic [DW-1:0]   wb_dat_i,
    output logic [DW-1:0]   wb_dat_o,
    output logic            wb_ack_o,
    input  logic [N_EV-1:0] status_i,
    input  logic [N_EV-1:0] pend_i,
    output logic [N_EV-1:0] clr_o,
    output logic [N_EV-1:0] en_o
);
    import evirq_pkg::*;

    localparam int unsigned PADW = DW - N_EV;

    bus_state_e state_q, state_d;
    logic       access;
    logic [DW-1:0] rdata;

    assign access = (state_q == BUS_IDLE) && wb_cyc_i && wb_stb_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (access) state_d = BUS_ACK;
            BUS_ACK:  state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= BUS_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        wb_ack_o = 1'b0;
        unique case (state_q)
            BUS_IDLE: wb_ack_o = 1'b0;
            BUS_ACK:  wb_ack_o = 1'b1;
            default:  wb_ack_o = 1'b0;
        endcase
    end

    always_comb begin
        rdata = '0;
        unique case (int'(wb_adr_i))
            REG_STATUS:  rdata = {{PADW{1'b0}}, status_i};
            REG_PENDING: rdata = {{PADW{1'b0}}, pend_i};
            REG_ENABLE:  rdata = {{PADW{1'b0}}, en_o};
            default:     rdata = '0;
        endcase
    end

    assign clr_o = (access && wb_we_i && int'(wb_adr_i) == REG_PENDING)
                   ? wb_dat_i[N_EV-1:0] : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            en_o     <= '0;
            wb_dat_o <= '0;
        end else if (access) begin
            if (wb_we_i && int'(wb_adr_i) == REG_ENABLE) en_o <= wb_dat_i[N_EV-1:0];
            if (!wb_we_i) wb_dat_o <= rdata;
        end
    end

    // R10
    ack_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wb_ack_o |=> !wb_ack_o);

    // R10
    ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!wb_ack_o && wb_cyc_i && wb_stb_i) |=> wb_ack_o);
endmodule

// File: rtl/evirq_ctrl.sv
module evirq_ctrl #(
    parameter int unsigned       N_EV     = 3,
    parameter int unsigned       DW       = 8,
    parameter int unsigned       AW       = 2,
    parameter logic [2*N_EV-1:0] MODE_CFG = {2'd2, 2'd1, 2'd0}
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            wb_cyc_i,
    input  logic            wb_stb_i,
    input  logic            wb_we_i,
    input  logic [AW-1:0]   wb_adr_i,
    input  logic [DW-1:0]   wb_dat_i,
    output logic [DW-1:0]   wb_dat_o,
    output logic            wb_ack_o,
    input  logic [N_EV-1:0] ev_i,
    output logic            irq_o
);
    logic [N_EV-1:0] trig, clr, pend, en;

    evirq_detect #(.N_EV(N_EV), .MODE_CFG(MODE_CFG)) detect_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .ev_i(ev_i), .trig_o(trig)
    );

    evirq_pending #(.N_EV(N_EV)) pending_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(trig), .clr_i(clr), .pend_o(pend)
    );

    evirq_regs #(.N_EV(N_EV), .DW(DW), .AW(AW)) regs_i (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o),
        .wb_ack_o(wb_ack_o), .status_i(ev_i), .pend_i(pend),
        .clr_o(clr), .en_o(en)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_o <= 1'b0;
        else         irq_o <= |(pend & en);
    end

    // R6
    irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|(pend & en)) |=> irq_o);

    // R6
    irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en == '0) |=> !irq_o);
endmodule

// File: tb/evirq_ctrl_tb.sv
module evirq_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [1:0] adr = '0;
    logic [7:0] wdat = '0;
    logic [7:0] rdat;
    logic       ack;
    logic [2:0] ev = '0;
    logic       irq;
    int         n_run = 0, n_fail = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    evirq_ctrl dut_i (
        .clk_i(clk), .rst_ni(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb),
        .wb_we_i(we), .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat),
        .wb_ack_o(ack), .ev_i(ev), .irq_o(irq)
    );

    task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wb_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = a; wdat = d;
        @(negedge clk);
        chk("R10 write ack", {7'd0, ack}, 8'd1);
        cyc = 0; stb = 0; we = 0;
    endtask

    task automatic wb_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cyc = 1; stb = 1; we = 0; adr = a;
        @(negedge clk);
        d = rdat;
        cyc = 0; stb = 0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk("R11 irq after reset", {7'd0, irq}, 8'd0);
        chk("R11 ack after reset", {7'd0, ack}, 8'd0);
        wb_rd(2'd1, d); chk("R11 pending after reset", d, 8'd0);
        wb_rd(2'd2, d); chk("R11 enable after reset", d, 8'd0);
    endtask

    task automatic t_level();
        logic [7:0] d;
        @(negedge clk); ev = 3'b101;
        wb_rd(2'd0, d); chk("R1 status raw", d, 8'h05);
        wb_rd(2'd1, d); chk("R2 level pending", d, 8'h01);
        @(negedge clk);
        chk("R6 irq masked by zero enable", {7'd0, irq}, 8'd0);
        wb_wr(2'd2, 8'h07);
        @(negedge clk);
        chk("R6 irq after enable", {7'd0, irq}, 8'd1);
        wb_wr(2'd1, 8'h01);
        wb_rd(2'd1, d); chk("R8 level still pending", d, 8'h01);
        @(negedge clk);
        chk("R8 irq held", {7'd0, irq}, 8'd1);
        ev[0] = 1'b0;
        wb_wr(2'd1, 8'h01);
        @(negedge clk);
        chk("R5 irq drops after clear", {7'd0, irq}, 8'd0);
        wb_rd(2'd1, d); chk("R5 pending cleared", d, 8'h00);
    endtask

    task automatic t_rise();
        logic [7:0] d;
        @(negedge clk); ev[1] = 1'b1;
        wb_rd(2'd1, d); chk("R3 rising sets bit1 only", d, 8'h02);
        @(negedge clk);
        chk("R6 irq on rise", {7'd0, irq}, 8'd1);
        wb_wr(2'd1, 8'h00);
        wb_rd(2'd1, d); chk("R5 zero write keeps", d, 8'h02);
        wb_wr(2'd1, 8'h02);
        @(negedge clk);
        chk("R3 irq drops", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_fall();
        logic [7:0] d;
        @(negedge clk); ev[2] = 1'b0;
        wb_rd(2'd1, d); chk("R4 falling sets bit2 only", d, 8'h04);
        @(negedge clk);
        chk("R4 irq on fall", {7'd0, irq}, 8'd1);
        wb_wr(2'd1, 8'h04);
        @(negedge clk);
        chk("R4 irq drops", {7'd0, irq}, 8'd0);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        @(negedge clk); ev[1] = 1'b0;
        @(negedge clk); ev[1] = 1'b1;
        @(negedge clk); ev[1] = 1'b0;
        wb_rd(2'd1, d); chk("R3 pending before collision", d, 8'h02);
        @(negedge clk);
        cyc = 1; stb = 1; we = 1; adr = 2'd1; wdat = 8'h02; ev[1] = 1'b1;
        @(negedge clk);
        cyc = 0; stb = 0; we = 0;
        wb_rd(2'd1, d); chk("R9 set wins over clear", d, 8'h02);
        wb_wr(2'd1, 8'h02);
        wb_rd(2'd1, d); chk("R9 later clear works", d, 8'h00);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wb_wr(2'd0, 8'hFF);
        wb_rd(2'd0, d); chk("R1 status write ignored", d, {5'd0, ev});
        wb_wr(2'd2, 8'hFA);
        wb_rd(2'd2, d); chk("R7 enable width", d, 8'h02);
        wb_rd(2'd3, d); chk("R7 unmapped reads zero", d, 8'h00);
        @(negedge clk);
        cyc = 1; stb = 1; adr = 2'd2;
        @(negedge clk);
        chk("R10 ack rises", {7'd0, ack}, 8'd1);
        cyc = 0; stb = 0;
        @(negedge clk);
        chk("R10 ack one cycle", {7'd0, ack}, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_level();
        t_rise();
        t_fall();
        t_collide();
        t_regs();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule